// File: doc/BRIEF.md
# Multi-Device Boot Configuration Sequencer

After a hardware reset, this controller brings up one programmable logic device and then two signal processors. The steps run in a fixed order. First it pulses the device's program request low. It then fetches the device's configuration image byte by byte from an image store and shifts it out serially, most significant bit first, on a bit clock divided down from the system clock. It then checks the device's done flag and its active-low CRC-fail interrupt. If the load is good, it pulses a register clear into the device and releases the processor reset. It then streams four images over a serial data line that all targets share. Each processor is addressed by its own active-low chip select. The processors receive a clock that is the inverse of the clock sent to the programmable device. After each processor's initial image, its select is raised and the sequencer waits a bounded time for that processor's active-low acknowledge.

The retries are nested. A bad programmable-logic check repeats only the program pulse and the device load. A processor acknowledge timeout restarts everything from the program pulse and clears the inner retry count. When either limit runs out, the block parks in a sticky failed state with an error code until the next reset.

The states, in order, are:
- PROG: program pulse.
- PL_LOAD: device image shift.
- PL_CHECK: settle, then sample the flags.
- REG_CLR: register-clear pulse.
- DSP_RST: processor reset still held.
- D1_INIT and D1_WAIT: first processor initial image, then wait for its acknowledge.
- D2_INIT and D2_WAIT: the same for the second processor.
- D1_MAIN and D2_MAIN: main images.
- READY and FAILED: final states.

The transitions are:
- Timer expiry moves PROG→PL_LOAD, REG_CLR→DSP_RST and DSP_RST→D1_INIT.
- Shift completion leaves each load state.
- A good check moves PL_CHECK→REG_CLR.
- A bad check moves PL_CHECK→PROG (CRC retry), or PL_CHECK→FAILED once the CRC limit is reached.
- An acknowledge moves D1_WAIT→D2_INIT and D2_WAIT→D1_MAIN.
- An acknowledge timeout moves either wait state →PROG (processor retry), or →FAILED once the processor limit is reached.
- D2_MAIN→READY.

Top module: `boot_sequencer`

## Requirements
- R1: While reset is applied and in the first cycle after it, the outputs are as follows. `pl_prog_n`=0, `dsp_rst_n`=0, `pl_regclr_n`=1, both chip selects=1, `boot_ready`=0, `boot_failed`=0, `boot_err`=0.
- R2: Every low pulse on `pl_prog_n` lasts at least PULSE_CYC clock cycles. So does the low pulse on `pl_regclr_n`.
- R3: Image bits leave on `ser_data` most significant bit first. Each bit is held for one `pl_sclk` period of 2×HALF_DIV cycles, with `pl_sclk` low for the first half and high for the second, and the bit does not change while `pl_sclk` is high. During the programmable-device load, both chip selects are high.
- R4: `dsp_sclk` is always the inverse of `pl_sclk`.
- R5: After the device image, the block waits CHECK_CYC cycles and then samples the flags. If `pl_irq_n` is low or `pl_done` is low, it restarts from a new program pulse. It makes at most PL_RETRY_MAX (5) such restarts, so at most 6 program pulses in a row. After that it fails with `boot_err`=1.
- R6: Before any chip select goes low, `pl_regclr_n` has pulsed low after the last program pulse and `dsp_rst_n` is high. No chip select is low while `dsp_rst_n` is low.
- R7: After a processor's initial image, its select rises. If that processor's acknowledge is not seen low within ACK_TIMEOUT_CYC cycles, the next program pulse begins exactly ACK_TIMEOUT_CYC cycles after the rise. The whole sequence then reruns from the programmable-device load. The two selects are never low together.
- R8: At most ACK_RETRY_MAX (2) processor-stage restarts are made. After that the block fails with `boot_err`=2. Each processor restart clears the CRC retry count.
- R9: The image order is: device image (`img_id`=0), first processor initial image (1), second processor initial image (2), first processor main image (3), second processor main image (4). Images 1 and 3 are sent with `dsp1_cs_n` low, and images 2 and 4 with `dsp2_cs_n` low.
- R10: `boot_ready` is 1 only after all five images are sent and both acknowledges are low. It drops while either acknowledge is high.
- R11: Once `boot_failed` is 1, it and `boot_err` stay unchanged until reset.
- R12: Each image is read from address 0 upward, one byte per request. `img_req` stays high until `img_ack`, and `img_data` is taken in the `img_ack` cycle. The image ends with the byte returned with `img_last`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low hardware reset |
| img_req | output | 1 | Byte request to the image store |
| img_id | output | 3 | Image being read (0..4) |
| img_addr | output | ADDR_W | Byte address within the image |
| img_ack | input | 1 | Byte returned this cycle |
| img_data | input | 8 | Returned byte |
| img_last | input | 1 | Returned byte is the last of the image |
| pl_prog_n | output | 1 | Program request to the logic device, active low |
| pl_sclk | output | 1 | Bit clock to the logic device |
| ser_data | output | 1 | Shared serial data line |
| pl_done | input | 1 | Logic device configuration done |
| pl_irq_n | input | 1 | Logic device interrupt, low means CRC failure |
| pl_regclr_n | output | 1 | Logic device register clear, active low |
| dsp_rst_n | output | 1 | Processor reset, active low |
| dsp_sclk | output | 1 | Bit clock to the processors (inverted) |
| dsp1_cs_n | output | 1 | First processor select, active low |
| dsp2_cs_n | output | 1 | Second processor select, active low |
| dsp1_ack_n | input | 1 | First processor download OK, active low |
| dsp2_ack_n | input | 1 | Second processor download OK, active low |
| boot_ready | output | 1 | All stages done and both acknowledges low |
| boot_failed | output | 1 | Retries exhausted (sticky) |
| boot_err | output | 2 | 0 none, 1 CRC/done failure, 2 acknowledge timeout |

## Verification
The assertions assume that the image store holds `img_data` and `img_last` valid only in the `img_ack` cycle and never acknowledges without a pending request. They also assume that the flag and acknowledge inputs change slowly compared to the two-flop synchronisers. The stimulus answers each request exactly one cycle after it is seen, always ends an image with `img_last`, and changes the flag inputs only on falling clock edges. An acknowledge is pulled low only a fixed delay after its select rises and is released whenever `dsp_rst_n` is low, as a processor coming out of reset would behave.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

    typedef enum logic [3:0] {
        ST_PROG,
        ST_PL_LOAD,
        ST_PL_CHECK,
        ST_REG_CLR,
        ST_DSP_RST,
        ST_D1_INIT,
        ST_D1_WAIT,
        ST_D2_INIT,
        ST_D2_WAIT,
        ST_D1_MAIN,
        ST_D2_MAIN,
        ST_READY,
        ST_FAILED
    } boot_state_e;

    typedef enum logic [1:0] {
        ERR_NONE = 2'd0,
        ERR_CRC  = 2'd1,
        ERR_ACK  = 2'd2
    } boot_err_e;

    localparam logic [2:0] IMG_PL      = 3'd0;
    localparam logic [2:0] IMG_P1_INIT = 3'd1;
    localparam logic [2:0] IMG_P2_INIT = 3'd2;
    localparam logic [2:0] IMG_P1_MAIN = 3'd3;
    localparam logic [2:0] IMG_P2_MAIN = 3'd4;

endpackage

// File: rtl/boot_interval.sv
module boot_interval #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] limit,
    output logic         hit
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (cnt_q < limit - W'(1)) begin
            cnt_q <= cnt_q + W'(1);
        end
    end

    assign hit = (cnt_q == limit - W'(1));

    // R2 / R7: the running count never passes the window it measures
    p_cnt_in_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && limit != '0) |-> (cnt_q < limit))
        else $error("interval counter ran past its limit");

endmodule

// File: rtl/boot_bit_shifter.sv
module boot_bit_shifter #(
    parameter int HALF_DIV = 20,
    parameter int ADDR_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              img_req,
    output logic [ADDR_W-1:0] img_addr,
    input  logic              img_ack,
    input  logic [7:0]        img_data,
    input  logic              img_last,
    output logic              sclk,
    output logic              sdata,
    output logic              done
);

    localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    typedef enum logic [1:0] {SH_IDLE, SH_FETCH, SH_LOW, SH_HIGH} sh_state_e;

    sh_state_e         sh_q, sh_d;
    logic [DW-1:0]     div_q;
    logic [2:0]        bit_q;
    logic [7:0]        shreg_q;
    logic              last_q;
    logic [ADDR_W-1:0] addr_q;
    logic              done_q;
    logic              half_end;

    assign half_end = (div_q == DW'(HALF_DIV - 1));

    always_comb begin
        sh_d = sh_q;
        unique case (sh_q)
            SH_IDLE:  if (start)    sh_d = SH_FETCH;
            SH_FETCH: if (img_ack)  sh_d = SH_LOW;
            SH_LOW:   if (half_end) sh_d = SH_HIGH;
            SH_HIGH:  if (half_end) begin
                if (bit_q != 3'd7) sh_d = SH_LOW;
                else if (last_q)   sh_d = SH_IDLE;
                else               sh_d = SH_FETCH;
            end
            default: sh_d = SH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q    <= SH_IDLE;
            div_q   <= '0;
            bit_q   <= '0;
            shreg_q <= '0;
            last_q  <= 1'b0;
            addr_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            sh_q   <= sh_d;
            done_q <= 1'b0;
            if (sh_d != sh_q)                      div_q <= '0;
            else if (sh_q == SH_LOW || sh_q == SH_HIGH) div_q <= div_q + DW'(1);
            if (sh_q == SH_IDLE && start) addr_q <= '0;
            if (sh_q == SH_FETCH && img_ack) begin
                shreg_q <= img_data;
                last_q  <= img_last;
                bit_q   <= '0;
            end
            if (sh_q == SH_HIGH && half_end) begin
                shreg_q <= {shreg_q[6:0], 1'b0};
                bit_q   <= bit_q + 3'd1;
                if (bit_q == 3'd7) begin
                    if (last_q) done_q <= 1'b1;
                    else        addr_q <= addr_q + ADDR_W'(1);
                end
            end
        end
    end

    assign img_req  = (sh_q == SH_FETCH);
    assign img_addr = addr_q;
    assign sclk     = (sh_q == SH_HIGH);
    assign sdata    = shreg_q[7];
    assign done     = done_q;

    p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (img_req && !img_ack) |=> img_req)
        else $error("byte request withdrawn before acknowledge");

    p_data_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(sdata))
        else $error("serial data moved while bit clock high");

    p_addr_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        img_req |=> $stable(img_addr))
        else $error("address moved during a request");

endmodule

// File: rtl/boot_sequencer.sv
module boot_sequencer
    import boot_seq_pkg::*;
#(
    parameter int HALF_DIV        = 20,
    parameter int PULSE_CYC       = 40,
    parameter int CHECK_CYC       = 8,
    parameter int ACK_TIMEOUT_CYC = 600000,
    parameter int PL_RETRY_MAX    = 5,
    parameter int ACK_RETRY_MAX   = 2,
    parameter int ADDR_W          = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              img_req,
    output logic [2:0]        img_id,
    output logic [ADDR_W-1:0] img_addr,
    input  logic              img_ack,
    input  logic [7:0]        img_data,
    input  logic              img_last,
    output logic              pl_prog_n,
    output logic              pl_sclk,
    output logic              ser_data,
    input  logic              pl_done,
    input  logic              pl_irq_n,
    output logic              pl_regclr_n,
    output logic              dsp_rst_n,
    output logic              dsp_sclk,
    output logic              dsp1_cs_n,
    output logic              dsp2_cs_n,
    input  logic              dsp1_ack_n,
    input  logic              dsp2_ack_n,
    output logic              boot_ready,
    output logic              boot_failed,
    output logic [1:0]        boot_err
);

    localparam int TMAX0 = (PULSE_CYC > CHECK_CYC) ? PULSE_CYC : CHECK_CYC;
    localparam int TMAX  = (ACK_TIMEOUT_CYC > TMAX0) ? ACK_TIMEOUT_CYC : TMAX0;
    localparam int TW    = $clog2(TMAX + 1);
    localparam int PFW   = $clog2(PL_RETRY_MAX + 1);
    localparam int AFW   = $clog2(ACK_RETRY_MAX + 1);
    localparam int NSYNC = 4;

    // ---- input synchronisers: {ack2, ack1, irq, done}
    logic [NSYNC-1:0] raw_in, sync_out;
    localparam logic [NSYNC-1:0] SYNC_RST = 4'b1110;
    assign raw_in = {dsp2_ack_n, dsp1_ack_n, pl_irq_n, pl_done};

    for (genvar g = 0; g < NSYNC; g++) begin : g_sync
        logic [1:0] ff_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff_q <= {2{SYNC_RST[g]}};
            else        ff_q <= {ff_q[0], raw_in[g]};
        end
        assign sync_out[g] = ff_q[1];
    end

    logic done_s, irq_n_s, ack1_n_s, ack2_n_s;
    assign {ack2_n_s, ack1_n_s, irq_n_s, done_s} = sync_out;

    // ---- state and retry bookkeeping
    boot_state_e    state_q, state_d;
    boot_err_e      err_q, err_d;
    logic [PFW-1:0] pl_fail_q;
    logic [AFW-1:0] ack_fail_q;
    logic           pl_fail_inc, ack_fail_inc;
    logic           ack_timeout;
    logic           t_hit, sh_done, sh_start, sh_sclk, sh_data;
    logic [TW-1:0]  t_limit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_PROG;
            err_q      <= ERR_NONE;
            pl_fail_q  <= '0;
            ack_fail_q <= '0;
        end else begin
            state_q <= state_d;
            err_q   <= err_d;
            if (ack_fail_inc) begin
                ack_fail_q <= ack_fail_q + AFW'(1);
                pl_fail_q  <= '0;
            end else if (pl_fail_inc) begin
                pl_fail_q <= pl_fail_q + PFW'(1);
            end
        end
    end

    always_comb begin
        state_d      = state_q;
        err_d        = err_q;
        pl_fail_inc  = 1'b0;
        ack_fail_inc = 1'b0;
        ack_timeout  = 1'b0;
        unique case (state_q)
            ST_PROG:     if (t_hit)   state_d = ST_PL_LOAD;
            ST_PL_LOAD:  if (sh_done) state_d = ST_PL_CHECK;
            ST_PL_CHECK: if (t_hit) begin
                if (done_s && irq_n_s) begin
                    state_d = ST_REG_CLR;
                end else if (pl_fail_q == PFW'(PL_RETRY_MAX)) begin
                    state_d = ST_FAILED;
                    err_d   = ERR_CRC;
                end else begin
                    state_d     = ST_PROG;
                    pl_fail_inc = 1'b1;
                end
            end
            ST_REG_CLR:  if (t_hit)   state_d = ST_DSP_RST;
            ST_DSP_RST:  if (t_hit)   state_d = ST_D1_INIT;
            ST_D1_INIT:  if (sh_done) state_d = ST_D1_WAIT;
            ST_D1_WAIT:  if (!ack1_n_s) state_d = ST_D2_INIT;
                         else if (t_hit) ack_timeout = 1'b1;
            ST_D2_INIT:  if (sh_done) state_d = ST_D2_WAIT;
            ST_D2_WAIT:  if (!ack2_n_s) state_d = ST_D1_MAIN;
                         else if (t_hit) ack_timeout = 1'b1;
            ST_D1_MAIN:  if (sh_done) state_d = ST_D2_MAIN;
            ST_D2_MAIN:  if (sh_done) state_d = ST_READY;
            ST_READY:    state_d = ST_READY;
            ST_FAILED:   state_d = ST_FAILED;
            default:     state_d = ST_FAILED;
        endcase
        if (ack_timeout) begin
            if (ack_fail_q == AFW'(ACK_RETRY_MAX)) begin
                state_d = ST_FAILED;
                err_d   = ERR_ACK;
            end else begin
                state_d      = ST_PROG;
                ack_fail_inc = 1'b1;
            end
        end
    end

    // ---- timer window per state
    always_comb begin
        unique case (state_q)
            ST_PROG, ST_REG_CLR, ST_DSP_RST: t_limit = TW'(PULSE_CYC);
            ST_PL_CHECK:                     t_limit = TW'(CHECK_CYC);
            ST_D1_WAIT, ST_D2_WAIT:          t_limit = TW'(ACK_TIMEOUT_CYC);
            default:                         t_limit = TW'(1);
        endcase
    end

    boot_interval #(.W(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_d != state_q),
        .limit (t_limit),
        .hit   (t_hit)
    );

    function automatic logic is_load(boot_state_e s);
        return (s == ST_PL_LOAD) || (s == ST_D1_INIT) || (s == ST_D2_INIT) ||
               (s == ST_D1_MAIN) || (s == ST_D2_MAIN);
    endfunction

    assign sh_start = (state_d != state_q) && is_load(state_d);

    boot_bit_shifter #(.HALF_DIV(HALF_DIV), .ADDR_W(ADDR_W)) u_shifter (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (sh_start),
        .img_req  (img_req),
        .img_addr (img_addr),
        .img_ack  (img_ack),
        .img_data (img_data),
        .img_last (img_last),
        .sclk     (sh_sclk),
        .sdata    (sh_data),
        .done     (sh_done)
    );

    // ---- outputs
    always_comb begin
        img_id      = IMG_PL;
        pl_prog_n   = 1'b1;
        pl_regclr_n = 1'b1;
        dsp_rst_n   = 1'b1;
        dsp1_cs_n   = 1'b1;
        dsp2_cs_n   = 1'b1;
        unique case (state_q)
            ST_PROG:     begin pl_prog_n   = 1'b0; dsp_rst_n = 1'b0; end
            ST_PL_LOAD,
            ST_PL_CHECK: dsp_rst_n = 1'b0;
            ST_REG_CLR:  begin pl_regclr_n = 1'b0; dsp_rst_n = 1'b0; end
            ST_DSP_RST:  dsp_rst_n = 1'b0;
            ST_D1_INIT:  begin dsp1_cs_n = 1'b0; img_id = IMG_P1_INIT; end
            ST_D2_INIT:  begin dsp2_cs_n = 1'b0; img_id = IMG_P2_INIT; end
            ST_D1_MAIN:  begin dsp1_cs_n = 1'b0; img_id = IMG_P1_MAIN; end
            ST_D2_MAIN:  begin dsp2_cs_n = 1'b0; img_id = IMG_P2_MAIN; end
            ST_FAILED:   dsp_rst_n = 1'b0;
            default:     ;
        endcase
    end

    assign pl_sclk     = sh_sclk;
    assign dsp_sclk    = ~sh_sclk;
    assign ser_data    = sh_data;
    assign boot_ready  = (state_q == ST_READY) && !ack1_n_s && !ack2_n_s;
    assign boot_failed = (state_q == ST_FAILED);
    assign boot_err    = err_q;

    // ---- checks
    logic [TW-1:0] prog_low_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               prog_low_q <= '0;
        else if (pl_prog_n)                       prog_low_q <= '0;
        else if (prog_low_q != TW'(PULSE_CYC))    prog_low_q <= prog_low_q + TW'(1);
    end

    p_prog_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pl_prog_n) |-> (prog_low_q >= TW'(PULSE_CYC)))
        else $error("program pulse too short");

    p_cs_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dsp1_cs_n && !dsp2_cs_n))
        else $error("both selects low");

    p_no_cs_in_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !dsp_rst_n |-> (dsp1_cs_n && dsp2_cs_n))
        else $error("select low while processors held in reset");

    p_fail_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        boot_failed |=> (boot_failed && $stable(boot_err)))
        else $error("failed state left");

    p_ready_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        boot_ready |-> (dsp1_cs_n && dsp2_cs_n && dsp_rst_n && !img_req))
        else $error("ready while still loading");

    p_retry_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pl_fail_q <= PFW'(PL_RETRY_MAX)) && (ack_fail_q <= AFW'(ACK_RETRY_MAX)))
        else $error("retry counter past its limit");

endmodule

// File: tb/boot_sequencer_bench.sv
module boot_sequencer_bench;

    localparam int HALF_DIV = 2;
    localparam int PULSE    = 5;
    localparam int CHECK    = 3;
    localparam int TMO      = 200;
    localparam int AW       = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          img_req, img_ack, img_last;
    logic [2:0]    img_id;
    logic [AW-1:0] img_addr;
    logic [7:0]    img_data;
    logic pl_prog_n, pl_sclk, ser_data, pl_done, pl_irq_n, pl_regclr_n;
    logic dsp_rst_n, dsp_sclk, dsp1_cs_n, dsp2_cs_n, dsp1_ack_n, dsp2_ack_n;
    logic boot_ready, boot_failed;
    logic [1:0] boot_err;

    boot_sequencer #(
        .HALF_DIV(HALF_DIV), .PULSE_CYC(PULSE), .CHECK_CYC(CHECK),
        .ACK_TIMEOUT_CYC(TMO), .PL_RETRY_MAX(5), .ACK_RETRY_MAX(2), .ADDR_W(AW)
    ) u_boot_sequencer (
        .clk(clk), .rst_n(rst_n), .img_req(img_req), .img_id(img_id),
        .img_addr(img_addr), .img_ack(img_ack), .img_data(img_data),
        .img_last(img_last), .pl_prog_n(pl_prog_n), .pl_sclk(pl_sclk),
        .ser_data(ser_data), .pl_done(pl_done), .pl_irq_n(pl_irq_n),
        .pl_regclr_n(pl_regclr_n), .dsp_rst_n(dsp_rst_n), .dsp_sclk(dsp_sclk),
        .dsp1_cs_n(dsp1_cs_n), .dsp2_cs_n(dsp2_cs_n), .dsp1_ack_n(dsp1_ack_n),
        .dsp2_ack_n(dsp2_ack_n), .boot_ready(boot_ready),
        .boot_failed(boot_failed), .boot_err(boot_err)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int img_len(input int id);
        return (id == 0) ? 3 : 2;
    endfunction

    function automatic logic [7:0] img_byte(input int id, input int addr);
        return 8'hA5 ^ {id[2:0], addr[4:0]};
    endfunction

    // ---- scenario knobs
    int crc_fails  = 0;
    int d1_fail    = 0;
    int d2_fail    = 0;
    int ack_dly    = 10;
    bit force_hi   = 1'b0;

    // ---- scoreboard: {dest[2:0], byte}
    logic [10:0] exp_q[$];

    task automatic push_image(input int id);
        int dest;
        dest = (id == 0) ? 0 : ((id == 1 || id == 3) ? 1 : 2);
        for (int a = 0; a < img_len(id); a++)
            exp_q.push_back({dest[2:0], img_byte(id, a)});
    endtask

    // ---- image store responder
    always @(negedge clk) begin
        if (!rst_n) begin
            img_ack <= 1'b0; img_data <= '0; img_last <= 1'b0;
        end else if (img_req && !img_ack) begin
            img_ack  <= 1'b1;
            img_data <= img_byte(int'(img_id), int'(img_addr));
            img_last <= (int'(img_addr) == img_len(int'(img_id)) - 1);
        end else begin
            img_ack  <= 1'b0;
        end
    end

    // ---- edge tracking and device models
    int  cyc = 0;
    int  prog_rises = 0;
    int  low_run = 0;
    bit  width_bad = 1'b0;
    bit  inv_bad = 1'b0;
    bit  order_bad = 1'b0;
    bit  regclr_seen = 1'b0;
    int  cs_rise_cyc = -1;
    int  last_gap = -1;
    logic prev_prog = 1'b0, prev_sclk = 1'b0, prev_cs1 = 1'b1, prev_cs2 = 1'b1;
    logic prev_clr = 1'b1;
    logic a1 = 1'b1, a2 = 1'b1;
    int  c1 = -1, c2 = -1;
    logic [7:0] acc = '0;
    int  nbits = 0;

    assign pl_done  = 1'b1;
    assign pl_irq_n = !(prog_rises <= crc_fails);
    assign dsp1_ack_n = a1 | force_hi;
    assign dsp2_ack_n = a2;

    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            prog_rises = 0; low_run = 0; acc = '0; nbits = 0;
            regclr_seen = 1'b0; cs_rise_cyc = -1; last_gap = -1;
            a1 = 1'b1; a2 = 1'b1; c1 = -1; c2 = -1;
        end else begin
            if (dsp_sclk !== ~pl_sclk) inv_bad = 1'b1;
            // program pulse width and count
            if (!pl_prog_n) low_run++;
            if (pl_prog_n && !prev_prog) begin
                prog_rises++;
                if (low_run < PULSE) width_bad = 1'b1;
                low_run = 0;
                regclr_seen = 1'b0;
            end
            if (!pl_prog_n && prev_prog && cs_rise_cyc >= 0)
                last_gap = cyc - cs_rise_cyc;
            if (pl_regclr_n && !prev_clr) regclr_seen = 1'b1;
            if ((!dsp1_cs_n && prev_cs1) || (!dsp2_cs_n && prev_cs2))
                if (!regclr_seen || !dsp_rst_n) order_bad = 1'b1;
            if ((!dsp1_cs_n || !dsp2_cs_n) && !dsp_rst_n) order_bad = 1'b1;
            if (dsp1_cs_n && !prev_cs1) cs_rise_cyc = cyc;
            if (dsp2_cs_n && !prev_cs2) cs_rise_cyc = cyc;
            // processor acknowledge models
            if (!dsp_rst_n) begin
                a1 = 1'b1; a2 = 1'b1; c1 = -1; c2 = -1;
            end else begin
                if (dsp1_cs_n && !prev_cs1 && a1 && c1 < 0) begin
                    if (d1_fail > 0) d1_fail--; else c1 = ack_dly;
                end
                if (dsp2_cs_n && !prev_cs2 && a2 && c2 < 0) begin
                    if (d2_fail > 0) d2_fail--; else c2 = ack_dly;
                end
                if (c1 == 0) begin a1 = 1'b0; c1 = -1; end else if (c1 > 0) c1--;
                if (c2 == 0) begin a2 = 1'b0; c2 = -1; end else if (c2 > 0) c2--;
            end
            // scoreboard monitor: sample data at rising bit clock
            if (pl_sclk && !prev_sclk) begin
                acc = {acc[6:0], ser_data};
                nbits++;
                if (nbits == 8) begin
                    logic [2:0]  dest;
                    logic [10:0] e;
                    nbits = 0;
                    dest = !dsp1_cs_n ? 3'd1 : (!dsp2_cs_n ? 3'd2 : 3'd0);
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R9", "unexpected byte", int'({dest, acc}), -1);
                    end else begin
                        e = exp_q.pop_front();
                        // R3 MSB-first bits, R9 order/select, R12 address walk
                        chk({dest, acc} == e, "R3/R9/R12", "stream item",
                            int'({dest, acc}), int'(e));
                    end
                end
            end
        end
        prev_prog = pl_prog_n; prev_sclk = pl_sclk;
        prev_cs1 = dsp1_cs_n; prev_cs2 = dsp2_cs_n; prev_clr = pl_regclr_n;
    end

    // ---- watchdog
    bit wd_fired = 1'b0;
    initial begin
        repeat (150000) @(posedge clk);
        wd_fired = 1'b1;
        chk(1'b0, "ALL", "watchdog expired", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    task automatic do_reset;
        rst_n = 1'b0;
        exp_q.delete();
        width_bad = 1'b0; inv_bad = 1'b0; order_bad = 1'b0; force_hi = 1'b0;
        repeat (4) @(negedge clk);
        chk(!pl_prog_n && !dsp_rst_n && pl_regclr_n && dsp1_cs_n && dsp2_cs_n &&
            !boot_ready && !boot_failed && boot_err == 2'd0,
            "R1", "outputs in reset", 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!pl_prog_n && !dsp_rst_n && dsp1_cs_n && dsp2_cs_n && !boot_ready,
            "R1", "outputs after reset", int'(pl_prog_n), 0);
    endtask

    task automatic wait_end;
        int n;
        n = 0;
        while (!boot_ready && !boot_failed && n < 40000) begin
            @(negedge clk);
            n++;
        end
        repeat (20) @(negedge clk);
    endtask

    task automatic common_checks(input string tag);
        chk(exp_q.size() == 0, "R9", {tag, " queue drained"}, exp_q.size(), 0);
        chk(!width_bad, "R2", {tag, " program pulse width"}, int'(width_bad), 0);
        chk(!inv_bad, "R4", {tag, " inverted processor clock"}, int'(inv_bad), 0);
        chk(!order_bad, "R6", {tag, " clear/reset before select"}, int'(order_bad), 0);
    endtask

    initial begin
        img_ack = 1'b0; img_data = '0; img_last = 1'b0;

        // S1: clean boot, then acknowledge dependence of ready
        crc_fails = 0; d1_fail = 0; d2_fail = 0; ack_dly = 10;
        do_reset();
        push_image(0); push_image(1); push_image(2); push_image(3); push_image(4);
        wait_end();
        common_checks("S1");
        chk(boot_ready && !boot_failed, "R10", "S1 ready", int'(boot_ready), 1);
        chk(prog_rises == 1, "R5", "S1 one program pulse", prog_rises, 1);
        force_hi = 1'b1;
        repeat (5) @(negedge clk);
        chk(!boot_ready, "R10", "ready drops with ack high", int'(boot_ready), 0);
        force_hi = 1'b0;
        repeat (5) @(negedge clk);
        chk(boot_ready, "R10", "ready back with ack low", int'(boot_ready), 1);

        // S2: two CRC failures then success
        crc_fails = 2; d1_fail = 0; d2_fail = 0;
        do_reset();
        push_image(0); push_image(0); push_image(0);
        push_image(1); push_image(2); push_image(3); push_image(4);
        wait_end();
        common_checks("S2");
        chk(boot_ready, "R5", "S2 recovered", int'(boot_ready), 1);
        chk(prog_rises == 3, "R5", "S2 program pulses", prog_rises, 3);

        // S3: CRC never passes
        crc_fails = 1000;
        do_reset();
        for (int i = 0; i < 6; i++) push_image(0);
        wait_end();
        common_checks("S3");
        chk(boot_failed && boot_err == 2'd1, "R5", "S3 error code", int'(boot_err), 1);
        chk(prog_rises == 6, "R5", "S3 attempt count", prog_rises, 6);
        repeat (100) @(negedge clk);
        chk(boot_failed && boot_err == 2'd1 && !boot_ready, "R11", "S3 sticky",
            int'(boot_failed), 1);

        // S4: first processor never acknowledges
        crc_fails = 0; d1_fail = 1000; d2_fail = 0;
        do_reset();
        for (int i = 0; i < 3; i++) begin push_image(0); push_image(1); end
        wait_end();
        common_checks("S4");
        chk(boot_failed && boot_err == 2'd2, "R8", "S4 error code", int'(boot_err), 2);
        chk(prog_rises == 3, "R8", "S4 outer attempts", prog_rises, 3);
        chk(last_gap >= TMO && last_gap <= TMO + 2, "R7", "S4 timeout length",
            last_gap, TMO);
        repeat (50) @(negedge clk);
        chk(boot_failed && boot_err == 2'd2, "R11", "S4 sticky", int'(boot_err), 2);

        // S5: second processor misses once
        crc_fails = 0; d1_fail = 0; d2_fail = 1;
        do_reset();
        push_image(0); push_image(1); push_image(2);
        push_image(0); push_image(1); push_image(2); push_image(3); push_image(4);
        wait_end();
        common_checks("S5");
        chk(boot_ready, "R7", "S5 recovered after restart", int'(boot_ready), 1);
        chk(prog_rises == 2, "R7", "S5 program pulses", prog_rises, 2);

        // S6: acknowledge late but inside the window
        crc_fails = 0; d1_fail = 0; d2_fail = 0; ack_dly = TMO - 12;
        do_reset();
        push_image(0); push_image(1); push_image(2); push_image(3); push_image(4);
        wait_end();
        common_checks("S6");
        chk(boot_ready && prog_rises == 1, "R7", "S6 late ack accepted",
            prog_rises, 1);

        if (!wd_fired) begin
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule